// File: doc/BRIEF.md
# Pixel Region Hit Latency Buffer

This block is the shared digital logic behind one square region of sixteen pixels. On every bunch-crossing clock it samples a 16-bit hit flag vector and a 5-bit time-over-threshold charge for each pixel. Every crossing that holds at least one hit claims one buffer slot. The slot keeps the crossing count, the hit map and all sixteen charges. A free-running crossing counter provides the timestamps.

A slot waits for exactly `LATENCY` crossings, which defaults to 500 (12.5 µs at 40 MHz). On that crossing a trigger claims it for readout and the trigger tag is attached; with no trigger the slot is freed. Claimed slots leave through a valid/ready packet port. A packet carries the tag, the hit map and the charges of the hit pixels only, packed towards the low end of the charge bus. With the triggerless mode input high, each new crossing with hits is queued for readout at once and triggers are ignored. When every slot is in use, an incoming crossing is lost and a saturating overflow counter counts the loss.

Top module: `pixel_region_buffer`

## Requirements
- R1: After reset, `pkt_valid_o` is 0 and `ovf_cnt_o` is 0.
- R2: A crossing with hits that is captured at clock edge k is emitted as a packet when `trig_i` is high at edge k+`LATENCY`. `pkt_valid_o` is 1 right after that edge, and `pkt_tag_o` equals the `trig_tag_i` that was sampled with the trigger.
- R3: A trigger at any other edge does not emit that crossing. At edge k+`LATENCY` the slot is freed whether or not a trigger arrived, so a later trigger finds nothing.
- R4: Zero suppression. Charge lane i (bits `5*i+4:5*i`) of `pkt_tot_o` carries the charge of the i-th set bit of `pkt_map_o`, counting from bit 0 upward. Lanes above the number of hits are 0. A valid packet never has an empty map. Crossings without hits take no slot.
- R5: All hits of one crossing go into one slot. Bit p of `pkt_map_o` is pixel p, and the packet carries all of them together.
- R6: With all `DEPTH` slots in use, an incoming crossing with hits is dropped and `ovf_cnt_o` goes up by 1. The counter stops at its maximum value (15 by default) and never decreases.
- R7: While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, the packet stays unchanged on the port. No queued packet is lost. Queued packets leave in slot order, and slots are allocated lowest-free-first.
- R8: With `trigless_i` high, each crossing with hits is queued as soon as it is captured, with tag 0, and `trig_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | 16 | Per-pixel hit flags for this crossing |
| tot_i | input | 80 | Per-pixel 5-bit charge, pixel p in bits 5p+4:5p |
| trig_i | input | 1 | Trigger for the crossing `LATENCY` ago |
| trig_tag_i | input | 5 | Tag attached to the triggered packet |
| trigless_i | input | 1 | 1 = send every hit crossing without a trigger |
| pkt_valid_o | output | 1 | Packet available |
| pkt_ready_i | input | 1 | Downstream accepts the packet |
| pkt_tag_o | output | 5 | Trigger tag of the packet |
| pkt_map_o | output | 16 | Hit map of the packet |
| pkt_tot_o | output | 80 | Packed charges of the hit pixels |
| ovf_cnt_o | output | 4 | Saturating count of dropped crossings |

## Verification
The embedded properties check on every cycle that a stalled packet holds steady and that no empty packet is ever presented. They also check that the overflow count never decreases, that at most one slot reaches its trigger crossing at a time, and that a triggerless hit shows up on the next cycle. The directed scenarios are needed for the rest: the exact crossing at which a trigger matches, freeing on a missed trigger, the lane packing of charges, the effect of a full buffer, and the order in which several stalled packets drain.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SEND = 2'd2
  } slot_st_e;
endpackage

// File: rtl/prb_first_set.sv
module prb_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/prb_zs_pack.sv
module prb_zs_pack #(
  parameter int NPIX  = 16,
  parameter int TOT_W = 5,
  localparam int TW   = NPIX * TOT_W
) (
  input  logic [NPIX-1:0] map_i,
  input  logic [TW-1:0]   tot_i,
  output logic [TW-1:0]   tot_o
);
  always_comb begin
    int pos;
    pos   = 0;
    tot_o = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (map_i[p]) begin
        tot_o[pos*TOT_W +: TOT_W] = tot_i[p*TOT_W +: TOT_W];
        pos++;
      end
    end
  end
endmodule

// File: rtl/pixel_region_buffer.sv
module pixel_region_buffer
  import prb_pkg::*;
#(
  parameter int NPIX    = 16,
  parameter int TOT_W   = 5,
  parameter int DEPTH   = 8,
  parameter int TS_W    = 9,
  parameter int LATENCY = 500,
  parameter int TAG_W   = 5,
  parameter int OVF_W   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPIX-1:0]       hit_i,
  input  logic [NPIX*TOT_W-1:0] tot_i,
  input  logic                  trig_i,
  input  logic [TAG_W-1:0]      trig_tag_i,
  input  logic                  trigless_i,
  output logic                  pkt_valid_o,
  input  logic                  pkt_ready_i,
  output logic [TAG_W-1:0]      pkt_tag_o,
  output logic [NPIX-1:0]       pkt_map_o,
  output logic [NPIX*TOT_W-1:0] pkt_tot_o,
  output logic [OVF_W-1:0]      ovf_cnt_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = NPIX * TOT_W;
  localparam logic [TS_W-1:0] LAT_TS = TS_W'(LATENCY);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  slot_st_e         st_q [DEPTH];
  slot_st_e         st_d [DEPTH];
  logic [TS_W-1:0]  ts_q [DEPTH];
  logic [NPIX-1:0]  map_q [DEPTH];
  logic [TW-1:0]    tot_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TS_W-1:0]  age_w [DEPTH];

  logic [TS_W-1:0]  bx_q, bx_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             hold_q, hold_d;
  logic [IDX_W-1:0] hold_idx_q, hold_idx_d;

  logic [DEPTH-1:0] free_vec, send_vec, due_vec, load, tag_ld;
  logic             has_free, has_send;
  logic [IDX_W-1:0] free_idx, send_idx, sel_idx;
  logic             new_hit, alloc, drop, trig_ok, take;

  // Per-slot status vectors
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign age_w[g]    = bx_q - ts_q[g];
    assign free_vec[g] = (st_q[g] == SLOT_FREE);
    assign send_vec[g] = (st_q[g] == SLOT_SEND);
    assign due_vec[g]  = (st_q[g] == SLOT_WAIT) && (age_w[g] == LAT_TS);
  end

  prb_first_set #(.W(DEPTH)) u_free (
    .req_i(free_vec), .any_o(has_free), .idx_o(free_idx)
  );
  prb_first_set #(.W(DEPTH)) u_send (
    .req_i(send_vec), .any_o(has_send), .idx_o(send_idx)
  );

  assign new_hit     = |hit_i;
  assign alloc       = new_hit && has_free;
  assign drop        = new_hit && !has_free;
  assign trig_ok     = trig_i && !trigless_i;
  assign sel_idx     = hold_q ? hold_idx_q : send_idx;
  assign pkt_valid_o = hold_q || has_send;
  assign take        = pkt_valid_o && pkt_ready_i;

  // Slot next state
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      st_d[s]   = st_q[s];
      load[s]   = alloc && (free_idx == IDX_W'(s));
      tag_ld[s] = load[s] || (due_vec[s] && trig_ok);
      unique case (st_q[s])
        SLOT_FREE: if (load[s]) st_d[s] = trigless_i ? SLOT_SEND : SLOT_WAIT;
        SLOT_WAIT: if (due_vec[s]) st_d[s] = trig_ok ? SLOT_SEND : SLOT_FREE;
        SLOT_SEND: if (take && (sel_idx == IDX_W'(s))) st_d[s] = SLOT_FREE;
        default:   st_d[s] = SLOT_FREE;
      endcase
    end
  end

  always_comb begin
    bx_d       = bx_q + 1'b1;
    ovf_d      = (drop && (ovf_q != OVF_MAX)) ? ovf_q + 1'b1 : ovf_q;
    hold_d     = pkt_valid_o && !pkt_ready_i;
    hold_idx_d = sel_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) st_q[s] <= SLOT_FREE;
      bx_q       <= '0;
      ovf_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) st_q[s] <= st_d[s];
      bx_q       <= bx_d;
      ovf_q      <= ovf_d;
      hold_q     <= hold_d;
      hold_idx_q <= hold_idx_d;
    end
  end

  // Payload storage, enable-gated, no reset
  always_ff @(posedge clk_i) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (load[s]) begin
        ts_q[s]  <= bx_q;
        map_q[s] <= hit_i;
        tot_q[s] <= tot_i;
      end
      if (tag_ld[s]) tag_q[s] <= load[s] ? '0 : trig_tag_i;
    end
  end

  assign pkt_tag_o = tag_q[sel_idx];
  assign pkt_map_o = map_q[sel_idx];
  assign ovf_cnt_o = ovf_q;

  prb_zs_pack #(.NPIX(NPIX), .TOT_W(TOT_W)) u_pack (
    .map_i(pkt_map_o), .tot_i(tot_q[sel_idx]), .tot_o(pkt_tot_o)
  );

  // Assertions
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_map_o)
      && $stable(pkt_tag_o) && $stable(pkt_tot_o)));

  p_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_map_o != '0));

  p_ovf_mono_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_cnt_o >= $past(ovf_cnt_o));

  p_single_due_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(due_vec));

  p_trigless_now_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigless_i && new_hit && has_free) |=> pkt_valid_o);
endmodule

// File: tb/pixel_region_buffer_tb.sv
module pixel_region_buffer_tb;
  localparam int NPIX = 16, TOT_W = 5, LAT = 500, TAG_W = 5, OVF_W = 4;
  localparam int TW = NPIX * TOT_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [NPIX-1:0] hit;
  logic [TW-1:0] tot;
  logic trig, trigless, ready;
  logic [TAG_W-1:0] trig_tag;
  logic valid;
  logic [TAG_W-1:0] ptag;
  logic [NPIX-1:0] pmap;
  logic [TW-1:0] ptot;
  logic [OVF_W-1:0] ovf;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pixel_region_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .tot_i(tot), .trig_i(trig),
    .trig_tag_i(trig_tag), .trigless_i(trigless), .pkt_valid_o(valid),
    .pkt_ready_i(ready), .pkt_tag_o(ptag), .pkt_map_o(pmap),
    .pkt_tot_o(ptot), .ovf_cnt_o(ovf)
  );

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk_tot(int seed);
    logic [TW-1:0] v;
    for (int p = 0; p < NPIX; p++) v[p*TOT_W +: TOT_W] = TOT_W'((p * seed + 3) % 32);
    return v;
  endfunction

  function automatic logic [TW-1:0] exp_pack(logic [NPIX-1:0] m, logic [TW-1:0] t);
    logic [TW-1:0] v;
    int k;
    v = '0;
    k = 0;
    for (int p = 0; p < NPIX; p++) begin
      if (m[p]) begin
        v[k*TOT_W +: TOT_W] = t[p*TOT_W +: TOT_W];
        k++;
      end
    end
    return v;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_hit(logic [NPIX-1:0] m, logic [TW-1:0] t);
    hit = m; tot = t;
    @(negedge clk);
    hit = '0; tot = '0;
  endtask

  task automatic fire(logic [TAG_W-1:0] tg);
    trig = 1'b1; trig_tag = tg;
    @(negedge clk);
    trig = 1'b0; trig_tag = '0;
  endtask

  task automatic t_reset;
    check("R1 valid", TW'(valid), TW'(0));
    check("R1 ovf", TW'(ovf), TW'(0));
  endtask

  task automatic t_match;
    logic [NPIX-1:0] m;
    logic [TW-1:0] t;
    m = 16'hA5C3; t = mk_tot(7);
    put_hit(m, t);
    idle(LAT - 1);
    fire(5'd19);
    check("R2 valid", TW'(valid), TW'(1));
    check("R2 tag", TW'(ptag), TW'(19));
    check("R5 map", TW'(pmap), TW'(m));
    check("R4 packed tot", ptot, exp_pack(m, t));
    idle(1);
    check("R2 popped", TW'(valid), TW'(0));
    m = 16'h8001; t = mk_tot(11);
    put_hit(m, t);
    idle(LAT - 1);
    fire(5'd3);
    check("R4 sparse map", TW'(pmap), TW'(m));
    check("R4 sparse tot", ptot, exp_pack(m, t));
    idle(1);
  endtask

  task automatic t_miss;
    put_hit(16'h0010, mk_tot(3));
    idle(LAT - 2);
    fire(5'd1);
    check("R3 early trigger", TW'(valid), TW'(0));
    idle(1);
    fire(5'd2);
    check("R3 late trigger", TW'(valid), TW'(0));
    idle(2);
    check("R3 nothing left", TW'(valid), TW'(0));
  endtask

  task automatic t_overflow;
    logic [TW-1:0] t0;
    t0 = mk_tot(5);
    put_hit(16'h0F00, t0);
    for (int i = 1; i < 8; i++) begin
      idle(2);
      put_hit(16'h0001 << i, mk_tot(i));
    end
    check("R4 empty crossings take no slot", TW'(ovf), TW'(0));
    put_hit(16'h4000, mk_tot(9));
    check("R6 first drop", TW'(ovf), TW'(1));
    for (int i = 0; i < 19; i++) put_hit(16'h0002, mk_tot(2));
    check("R6 saturate", TW'(ovf), TW'(15));
    idle(LAT - 1 - 41);
    fire(5'd9);
    check("R6 stored entry intact map", TW'(pmap), TW'(16'h0F00));
    check("R6 stored entry intact tot", ptot, exp_pack(16'h0F00, t0));
    idle(LAT);
    check("R6 no decrease", TW'(ovf), TW'(15));
  endtask

  task automatic t_stall;
    ready = 1'b0;
    put_hit(16'h0300, mk_tot(13));
    put_hit(16'h0044, mk_tot(17));
    idle(LAT - 2);
    fire(5'd21);
    check("R7 first valid", TW'(valid), TW'(1));
    check("R7 first tag", TW'(ptag), TW'(21));
    fire(5'd22);
    check("R7 held tag", TW'(ptag), TW'(21));
    idle(3);
    check("R7 held map", TW'(pmap), TW'(16'h0300));
    check("R7 held tot", ptot, exp_pack(16'h0300, mk_tot(13)));
    ready = 1'b1;
    @(negedge clk);
    check("R7 second valid", TW'(valid), TW'(1));
    check("R7 second tag", TW'(ptag), TW'(22));
    check("R7 second map", TW'(pmap), TW'(16'h0044));
    @(negedge clk);
    check("R7 drained", TW'(valid), TW'(0));
  endtask

  task automatic t_trigless;
    logic [TW-1:0] t;
    t = mk_tot(23);
    trigless = 1'b1;
    put_hit(16'h1248, t);
    check("R8 immediate valid", TW'(valid), TW'(1));
    check("R8 tag zero", TW'(ptag), TW'(0));
    check("R8 map", TW'(pmap), TW'(16'h1248));
    check("R8 tot", ptot, exp_pack(16'h1248, t));
    idle(1);
    check("R8 popped", TW'(valid), TW'(0));
    fire(5'd7);
    check("R8 trigger ignored", TW'(valid), TW'(0));
    idle(LAT + 2);
    fire(5'd8);
    check("R8 no late match", TW'(valid), TW'(0));
    trigless = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit = '0; tot = '0; trig = 1'b0; trig_tag = '0;
    trigless = 1'b0; ready = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_match();
    t_miss();
    t_stall();
    t_trigless();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule